// File: doc/BRIEF.md
# Bit-Matrix Substitution-Linear Round Engine

This block is the iterative datapath of a 128-bit tweakable block cipher. The 128-bit state is treated as a matrix of 8 rows by 16 columns, with bit `r*16 + c` at row r, column c. Each round passes every 8-bit column through a bitsliced substitution box, adds a round constant, and then passes every 16-bit row through a binary linear map. Two rounds form a step. At the end of every step a 128-bit tweakey word is XORed into the state. An external schedule supplies that word on `tk_in` for the step index the engine shows on `tk_idx`. The substitution box, the linear box and the round constant are package functions, so another variant can be swapped in without touching the control.

A block enters through a valid/ready handshake on `in_valid`/`in_ready`. One extra cycle whitens the state with tweakey word 0. The rounds then run at one round per clock (`UNROLL=1`) or one full step per clock (`UNROLL=2`). `done` pulses for a single cycle when the ciphertext on `ct` is valid. The output has no back-pressure. The value on `ct` stays readable as described in R8. The `tk_in` word must be valid in the same cycle as the `tk_idx` it answers. The schedule must keep the tweakey it serves unchanged for the whole run.

Top module: `slre_round_engine`

## Requirements
- R1: `in_ready` is 1 exactly when the engine is idle. A block is taken in on a clock edge where `in_valid` and `in_ready` are both 1. While `in_ready` is 0, `in_valid` has no effect: the result and the timing of `done` are those of the block already running.
- R2: In the cycle after acceptance, `tk_idx` is 0. At the end of that cycle the state becomes `pt` XOR `tk_in`.
- R3: A round first replaces each column c by `sbox8` of the byte whose bit r is state bit `r*16+c`. It then XORs in the constant (R10). Last, it replaces each row word `state[r*16 +: 16]` by `lbox16` of that word.
- R4: After rounds 2s and 2s+1 the state is XORed with `tk_in` while `tk_idx` equals s+1. In round cycle j (counted from 0), `tk_idx` = j*UNROLL/2 + 1.
- R5: With the default `NR=20` (10 steps), the ciphertext equals the behavioural composition of R2, R3, R4 and R10 over all 20 rounds.
- R6: `done` is 1 after the clock edge that lies NR/UNROLL + 1 edges after the acceptance edge. This gives 21 cycles with one round per clock and 11 cycles with one step per clock.
- R7: `done` is high for one cycle only, and `in_ready` is 1 in that cycle. A block offered in that cycle is accepted at once, with no gap.
- R8: With `OUT_REG=1`, `ct` comes from a register that keeps the previous result while the next block is computed. With `OUT_REG=0`, `ct` is the state register. It is valid from `done` until the next acceptance.
- R9: After reset, `in_ready` is 1, `done` is 0, `ct` is 0 and `tk_idx` is 0.
- R10: Round k XORs `round_const(k)` into the state between the substitution and linear layers. `round_const(k)` puts `{k ^ 8'hC3, ~k}` in row 0, `{k, k ^ 8'h3C}` in row 7, and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Plaintext offered |
| in_ready | output | 1 | Engine idle, plaintext can be taken |
| pt | input | 128 | Plaintext block |
| tk_idx | output | 4 | Step index whose tweakey is needed now |
| tk_in | input | 128 | Tweakey word for `tk_idx` |
| done | output | 1 | One-cycle pulse, ciphertext valid |
| ct | output | 128 | Ciphertext |

## Verification
The bench builds two engines side by side. One runs one full step per clock with the output register present. The other runs one round per clock and drives `ct` straight from the state. Between them they cover both unroll branches, both output variants, and latencies of 11 and 21 cycles. Because the two engines finish at different times, a start offered while the slower one is busy is taken by the faster one and ignored by the slower one. Holding `in_valid` high produces back-to-back runs. Feeding a new plaintext shows whether the registered output keeps the old result.

// File: rtl/slre_pkg.sv
package slre_pkg;
  localparam int ROWS = 8;
  localparam int COLS = 16;
  localparam int BW   = ROWS * COLS;

  typedef logic [BW-1:0] blk_t;

  // Nonlinear 4-bit mixing used on each half of the bitsliced S-box
  function automatic logic [3:0] mix4(logic [3:0] v);
    return {(v[2] & v[1]) ^ v[0],
            (v[1] & v[0]) ^ v[3],
            (v[0] & v[3]) ^ v[2],
            (v[3] & v[2]) ^ v[1]};
  endfunction

  // Three-pass Feistel-like 8-bit substitution, gate level only
  function automatic logic [7:0] sbox8(logic [7:0] x);
    logic [3:0] a, b;
    a = x[7:4];
    b = x[3:0];
    b = b ^ mix4(a);
    a = a ^ mix4(b);
    b = b ^ mix4(a);
    return {a, b};
  endfunction

  // Binary linear map on one 16-bit row
  function automatic logic [15:0] lbox16(logic [15:0] x);
    return x ^ {x[14:0], x[15]} ^ {x[11:0], x[15:12]} ^ {x[6:0], x[15:7]};
  endfunction

  // Counter-indexed round constant
  function automatic blk_t round_const(logic [7:0] k);
    blk_t c;
    c = '0;
    c[15:0]       = {k ^ 8'hC3, ~k};
    c[BW-1:BW-16] = {k, k ^ 8'h3C};
    return c;
  endfunction
endpackage

// File: rtl/slre_sbox_layer.sv
module slre_sbox_layer
  import slre_pkg::*;
(
  input  logic [BW-1:0] din,
  output logic [BW-1:0] dout
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] cin;
    logic [ROWS-1:0] cout;
    for (genvar r = 0; r < ROWS; r++) begin : g_bit
      assign cin[r]            = din[r*COLS + c];
      assign dout[r*COLS + c]  = cout[r];
    end
    assign cout = sbox8(cin);
  end
endmodule

// File: rtl/slre_lbox_layer.sv
module slre_lbox_layer
  import slre_pkg::*;
(
  input  logic [BW-1:0] din,
  output logic [BW-1:0] dout
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign dout[r*COLS +: COLS] = lbox16(din[r*COLS +: COLS]);
  end
endmodule

// File: rtl/slre_round.sv
module slre_round
  import slre_pkg::*;
(
  input  logic [BW-1:0] din,
  input  logic [7:0]    rnd,
  output logic [BW-1:0] dout
);
  logic [BW-1:0] sub_out;
  logic [BW-1:0] key_out;

  slre_sbox_layer u_sub (.din(din), .dout(sub_out));

  assign key_out = sub_out ^ round_const(rnd);

  slre_lbox_layer u_lin (.din(key_out), .dout(dout));
endmodule

// File: rtl/slre_ctrl.sv
module slre_ctrl #(
  parameter int NR     = 20,
  parameter int UNROLL = 1,
  localparam int NCYC   = NR / UNROLL,
  localparam int NSTEPS = NR / 2,
  localparam int CW     = $clog2(NCYC),
  localparam int IW     = $clog2(NSTEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          load,
  output logic          init,
  output logic          run,
  output logic          fin,
  output logic [7:0]    rnd0,
  output logic [IW-1:0] tk_idx
);
  typedef enum logic [1:0] {S_IDLE, S_INIT, S_RUN} st_e;

  st_e           st;
  logic [CW-1:0] cnt;

  assign in_ready = (st == S_IDLE);
  assign load     = in_ready && in_valid;
  assign init     = (st == S_INIT);
  assign run      = (st == S_RUN);
  assign fin      = run && (cnt == CW'(NCYC - 1));
  assign rnd0     = 8'(int'(cnt) * UNROLL);
  assign tk_idx   = run ? IW'(int'(cnt) * UNROLL / 2 + 1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) st <= S_INIT;
        S_INIT: begin
          st  <= S_RUN;
          cnt <= '0;
        end
        S_RUN: begin
          if (fin) st <= S_IDLE;
          else     cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slre_round_engine.sv
module slre_round_engine
  import slre_pkg::*;
#(
  parameter int NR      = 20,
  parameter int UNROLL  = 1,
  parameter bit OUT_REG = 0,
  localparam int NSTEPS = NR / 2,
  localparam int IW     = $clog2(NSTEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [BW-1:0] pt,
  output logic [IW-1:0] tk_idx,
  input  logic [BW-1:0] tk_in,
  output logic          done,
  output logic [BW-1:0] ct
);
  logic          load, init, run, fin;
  logic [7:0]    rnd0;
  logic [BW-1:0] state;
  logic [BW-1:0] rnd_out;
  logic [BW-1:0] nxt;
  logic          step_end;

  slre_ctrl #(.NR(NR), .UNROLL(UNROLL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .load(load), .init(init), .run(run), .fin(fin),
    .rnd0(rnd0), .tk_idx(tk_idx)
  );

  if (UNROLL == 2) begin : g_step
    logic [BW-1:0] mid;
    slre_round u_ra (.din(state), .rnd(rnd0),         .dout(mid));
    slre_round u_rb (.din(mid),   .rnd(rnd0 + 8'd1),  .dout(rnd_out));
    assign step_end = 1'b1;
  end else begin : g_single
    slre_round u_ra (.din(state), .rnd(rnd0), .dout(rnd_out));
    assign step_end = rnd0[0];
  end

  assign nxt = step_end ? (rnd_out ^ tk_in) : rnd_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= '0;
      done  <= 1'b0;
    end else begin
      done <= fin;
      if (load)      state <= pt;
      else if (init) state <= state ^ tk_in;
      else if (run)  state <= nxt;
    end
  end

  if (OUT_REG) begin : g_oreg
    logic [BW-1:0] ct_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ct_q <= '0;
      else if (fin) ct_q <= nxt;
    end
    assign ct = ct_q;
  end else begin : g_direct
    assign ct = state;
  end
endmodule

// File: rtl/slre_round_engine_chk.sv
module slre_round_engine_chk #(
  parameter int NR     = 20,
  parameter int UNROLL = 1,
  localparam int NCYC   = NR / UNROLL,
  localparam int NSTEPS = NR / 2,
  localparam int IW     = $clog2(NSTEPS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          done,
  input logic [IW-1:0] tk_idx
);
  logic [7:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   lat <= 8'hFF;
    else if (in_valid && in_ready) lat <= 8'd0;
    else if (lat != 8'hFF)        lat <= lat + 8'd1;
  end

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_init_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (tk_idx == '0));

  p_index_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tk_idx <= IW'(NSTEPS));

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == 8'(NCYC + 1)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);
endmodule

bind slre_round_engine slre_round_engine_chk #(.NR(NR), .UNROLL(UNROLL)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .tk_idx(tk_idx)
);

// File: tb/tb_slre_round_engine.sv
package tb_slre_pkg;
  import slre_pkg::*;

  function automatic blk_t tk_of(logic [3:0] idx, logic [31:0] seed);
    logic [31:0] m;
    m = seed ^ (32'h9E3779B9 * {28'd0, idx});
    return {m, ~m, {m[15:0], m[31:16]}, m ^ 32'h0F1E2D3C};
  endfunction

  function automatic blk_t ref_encrypt(blk_t p, logic [31:0] seed, int nr);
    blk_t s;
    logic [7:0] b;
    s = p ^ tk_of(4'd0, seed);
    for (int k = 0; k < nr; k++) begin
      for (int c = 0; c < COLS; c++) begin
        for (int r = 0; r < ROWS; r++) b[r] = s[r*COLS + c];
        b = sbox8(b);
        for (int r = 0; r < ROWS; r++) s[r*COLS + c] = b[r];
      end
      s = s ^ round_const(8'(k));
      for (int r = 0; r < ROWS; r++) s[r*COLS +: COLS] = lbox16(s[r*COLS +: COLS]);
      if (k % 2 == 1) s = s ^ tk_of(4'(k / 2 + 1), seed);
    end
    return s;
  endfunction
endpackage

module tb_ref #(
  parameter int NR     = 20,
  parameter int UNROLL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [127:0] pt,
  input  logic [31:0]  seed,
  output logic         m_busy,
  output logic         m_done,
  output logic         m_seen,
  output int           m_cnt,
  output logic [127:0] m_ct
);
  import tb_slre_pkg::*;
  localparam int NCYC = NR / UNROLL;
  logic [127:0] r_pt;
  logic [31:0]  r_seed;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_seen <= 0; m_cnt <= 0;
      m_ct <= '0; r_pt <= '0; r_seed <= '0;
    end else begin
      m_done <= 0;
      if (!m_busy) begin
        if (in_valid) begin
          m_busy <= 1; m_cnt <= 0; r_pt <= pt; r_seed <= seed;
        end
      end else if (m_cnt == NCYC) begin
        m_busy <= 0; m_done <= 1; m_seen <= 1;
        m_ct <= ref_encrypt(r_pt, r_seed, NR);
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end
endmodule

module tb_slre_round_engine;
  import tb_slre_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 20;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         in_valid = 0;
  logic [127:0] pt = '0;
  logic [31:0]  seed = 32'h1234_5678;
  int           n_run = 0;
  int           n_fail = 0;
  bit           finished = 0;

  logic         rdy_a, done_a, rdy_b, done_b;
  logic [3:0]   idx_a, idx_b;
  logic [127:0] ct_a, ct_b, tk_a, tk_b;

  logic         mb_a, md_a, ms_a, mb_b, md_b, ms_b;
  int           mc_a, mc_b;
  logic [127:0] mct_a, mct_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tk_a = tk_of(idx_a, seed);
  assign tk_b = tk_of(idx_b, seed);

  // one step per clock, registered output
  slre_round_engine #(.NR(NR), .UNROLL(2), .OUT_REG(1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
    .pt(pt), .tk_idx(idx_a), .tk_in(tk_a), .done(done_a), .ct(ct_a));

  // one round per clock, state drives output
  slre_round_engine #(.NR(NR), .UNROLL(1), .OUT_REG(0)) dut_r (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
    .pt(pt), .tk_idx(idx_b), .tk_in(tk_b), .done(done_b), .ct(ct_b));

  tb_ref #(.NR(NR), .UNROLL(2)) ref_a (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .pt(pt), .seed(seed), .m_busy(mb_a), .m_done(md_a), .m_seen(ms_a), .m_cnt(mc_a), .m_ct(mct_a));
  tb_ref #(.NR(NR), .UNROLL(1)) ref_b (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .pt(pt), .seed(seed), .m_busy(mb_b), .m_done(md_b), .m_seen(ms_b), .m_cnt(mc_b), .m_ct(mct_b));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic check_inst(input string nm, input int unroll, input bit oreg,
                            input logic rdy, input logic dn, input logic [3:0] idx,
                            input logic [127:0] ct, input logic mb, input logic md,
                            input logic ms, input int mc, input logic [127:0] mct);
    int eidx;
    chk(rdy == !mb, {"R1 in_ready ", nm}, 128'(rdy), 128'(!mb));
    chk(dn == md, {"R6 R7 done timing ", nm}, 128'(dn), 128'(md));
    if (md) chk(ct == mct, {"R3 R5 R10 ciphertext ", nm}, ct, mct);
    if (ms && (!mb || oreg)) chk(ct == mct, {"R8 output hold ", nm}, ct, mct);
    if (mb) begin
      eidx = (mc == 0) ? 0 : ((mc - 1) * unroll) / 2 + 1;
      chk(idx == 4'(eidx), (mc == 0) ? {"R2 init index ", nm} : {"R4 step index ", nm},
          128'(idx), 128'(eidx));
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(rdy_a && rdy_b, "R9 reset ready", 128'({rdy_a, rdy_b}), 128'(3));
      chk(!done_a && !done_b, "R9 reset done", 128'({done_a, done_b}), 128'(0));
      chk(ct_a == '0 && ct_b == '0, "R9 reset ct", ct_a | ct_b, '0);
      chk(idx_a == '0 && idx_b == '0, "R9 reset index", 128'({idx_a, idx_b}), 128'(0));
    end else if (!finished) begin
      check_inst("step", 2, 1'b1, rdy_a, done_a, idx_a, ct_a, mb_a, md_a, ms_a, mc_a, mct_a);
      check_inst("round", 1, 1'b0, rdy_b, done_b, idx_b, ct_b, mb_b, md_b, ms_b, mc_b, mct_b);
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wait_idle();
    while (!(rdy_a && rdy_b)) tick();
    tick();
  endtask

  task automatic run_one(input logic [127:0] p, input logic [31:0] s);
    pt = p; seed = s; in_valid = 1;
    tick();
    in_valid = 0;
    wait_idle();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R5 R3 R10: several plaintext patterns
    run_one('0, 32'h0000_0000);
    run_one({128{1'b1}}, 32'hDEAD_BEEF);
    run_one(128'h0001_0002_0004_0008_0010_0020_0040_0080, 32'h0F0F_1234);
    for (int i = 0; i < 4; i++)
      run_one({$urandom, $urandom, $urandom, $urandom}, $urandom);
    // R1: start pulse while busy is ignored
    pt = 128'hA5A5_0000_FFFF_1234_5678_9ABC_DEF0_0F0F; in_valid = 1;
    tick(); in_valid = 0;
    repeat (3) tick();
    pt = 128'h1111_2222_3333_4444_5555_6666_7777_8888; in_valid = 1;
    tick(); in_valid = 0;
    wait_idle();
    // R7: back-to-back acceptance with in_valid held
    pt = 128'hCAFE_F00D_0000_0001_8000_0000_1234_4321; in_valid = 1;
    repeat (70) tick();
    in_valid = 0;
    wait_idle();
    // R8: new block while registered output holds the previous result
    run_one(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 32'h5555_AAAA);
    repeat (5) tick();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule